// File: doc/BRIEF.md
# Pointer-Addressed Control Register Bank

This block holds the byte-wide configuration registers of a clock-synthesizer control port. It sits behind a serial front end (I2C or SPI) that has already found the transaction boundaries and assembled bytes. The front end gives the bank three things. It pulses `xact_start` when a transaction is addressed to the device. It pulses `wr_valid` with a byte for each byte written. It pulses `rd_strobe` each time it needs a byte to send.

The first byte written after `xact_start` is the pointer byte. Bit 7 of that byte is the stepping flag for the transaction. Bits 6:0 are the register address. Each later byte is written to the pointed register, or read from it. After each such byte the pointer either stays where it is (flag 0) or moves up by one (flag 1). Flag 1 lets the front end write or read a run of registers, for example one of the four 32-bit ratio words. Each ratio word is stored as four consecutive bytes, with the most significant byte at the lowest address. Register 01h is a read-only identity byte. Reserved bits stay at zero.

The controller has three states:
- `ST_IDLE` is the state after reset. No transaction has started yet.
- `ST_PTR` waits for the pointer byte.
- `ST_DATA` moves data bytes.

It has four transitions:
- `xact_start` goes from any state to `ST_PTR`. This is the transition *begin*.
- A write in `ST_PTR` goes to `ST_DATA`. This is the transition *aim*.
- A read in `ST_PTR` goes to `ST_DATA` using the held pointer. This is the transition *resume*.
- Any byte in `ST_DATA` stays in `ST_DATA`. This is the transition *transfer*.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, every register reads 00h except the identity byte, `rd_data` is 00h, `dev_enabled` is 0, and the pointer is 00h with stepping off.
- R2: The first `wr_valid` byte after `xact_start` writes no register. Its bit 7 becomes the stepping flag and its bits 6:0 become the register address.
- R3: With the stepping flag at 0, every later written or read byte of the transaction uses the same register.
- R4: With the stepping flag at 1, the address goes up by one after each data byte written or read.
- R5: When stepping, address 7Fh is followed by 00h, and the stepping flag does not change.
- R6: Address 01h reads the fixed byte {DEV_CODE[4:0], REV_CODE[2:0]}, which is 1Ah by default. Writes to 01h have no effect.
- R7: Only writable bits are stored, and reserved bits read 0. The writable masks are:
  - 02h: 03h
  - 03h: FFh
  - 04h: 1Fh
  - 05h: 09h
  - 16h: 98h
  - 17h: 30h
  - 1Eh: E0h
- R8: Writes to unmapped addresses (00h, 18h–1Dh, 1Fh–7Fh) are ignored, and reads of those addresses return 00h.
- R9: Addresses 06h–15h are sixteen fully writable bytes that hold four 32-bit ratios, most significant byte first.
- R10: The pointer and the stepping flag are kept across transactions. A transaction that only reads continues from the last pointer.
- R11: `dev_enabled` is 1 exactly when bit 0 of 03h and bit 0 of 05h are both 1.
- R12: `rd_data` takes the pointed byte at the clock edge that samples `rd_strobe`, and otherwise holds its value.
- R13: Before the first `xact_start`, `wr_valid` and `rd_strobe` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xact_start | input | 1 | One-cycle pulse at the start of an addressed transaction |
| wr_valid | input | 1 | One-cycle pulse when a written byte is ready |
| wr_data | input | 8 | Written byte |
| rd_strobe | input | 1 | One-cycle request for the next read byte |
| rd_data | output | 8 | Byte fetched by the last read request |
| dev_enabled | output | 1 | Both device-enable bits are set |

## Verification
A wrong pointer shows at the ports on the next read. The byte that comes back belongs to a neighbouring or stale register, one cycle after the strobe. A wrong stepping flag shows as a run of bytes landing on one register, or a single-register access spreading to others. A corrupted write mask or a missed write shows as a changed read-back value the first time that register is read. For the enable bits, it shows on `dev_enabled` in the cycle after the write. Because the pointer persists, a state error in one transaction can also surface in a later read-only transaction. So several checks resume without sending a pointer byte.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2
    } crb_state_t;

    localparam int ID_ADDR   = 1;
    localparam int ENA_ADDR  = 3;
    localparam int ENB_ADDR  = 5;
    localparam int RATIO_LO  = 6;
    localparam int RATIO_HI  = 21;

    // Writable-bit mask per address; zero means nothing is stored there.
    function automatic logic [7:0] wmask(input int a);
        if (a >= RATIO_LO && a <= RATIO_HI) return 8'hFF;
        case (a)
            2:       return 8'h03;
            3:       return 8'hFF;
            4:       return 8'h1F;
            5:       return 8'h09;
            22:      return 8'h98;
            23:      return 8'h30;
            30:      return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/crb_pointer.sv
module crb_pointer #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        load_byte,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            mode <= 1'b0;
        end else if (load) begin
            addr <= load_byte[ADDR_W-1:0];
            mode <= load_byte[7];
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/crb_store.sv
module crb_store
    import crb_pkg::*;
#(
    parameter int         ADDR_W  = 7,
    parameter logic [7:0] ID_BYTE = 8'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rbyte,
    output logic              en_both
);
    localparam int NREG = 1 << ADDR_W;

    logic [7:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0] M = wmask(i);
        if (M != 8'h00) begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[i] <= 8'h00;
                else if (we && addr == ADDR_W'(i))
                    regs[i] <= wdata & M;
            end
        end else if (i == ID_ADDR) begin : g_id
            assign regs[i] = ID_BYTE;
        end else begin : g_none
            assign regs[i] = 8'h00;
        end
    end

    assign rbyte   = regs[addr];
    assign en_both = regs[ENA_ADDR][0] & regs[ENB_ADDR][0];
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import crb_pkg::*;
#(
    parameter int         ADDR_W   = 7,
    parameter logic [4:0] DEV_CODE = 5'h03,
    parameter logic [2:0] REV_CODE = 3'h2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xact_start,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       dev_enabled
);
    localparam logic [7:0] ID_BYTE = {DEV_CODE, REV_CODE};

    crb_state_t        state_q, state_d;
    logic              do_load, do_write, do_read, do_step;
    logic [ADDR_W-1:0] ptr_addr;
    logic              ptr_mode;
    logic [7:0]        fetch;
    logic              in_ptr, in_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and controls
    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_write = 1'b0;
        do_read  = 1'b0;
        do_step  = 1'b0;
        if (xact_start) begin
            state_d = ST_PTR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_PTR: begin
                    if (wr_valid) begin
                        do_load = 1'b1;
                        state_d = ST_DATA;
                    end else if (rd_strobe) begin
                        do_read = 1'b1;
                        do_step = ptr_mode;
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (wr_valid) begin
                        do_write = 1'b1;
                        do_step  = ptr_mode;
                    end else if (rd_strobe) begin
                        do_read = 1'b1;
                        do_step = ptr_mode;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign in_ptr  = (state_q == ST_PTR);
    assign in_data = (state_q == ST_DATA);

    crb_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_byte (wr_data),
        .step      (do_step),
        .addr      (ptr_addr),
        .mode      (ptr_mode)
    );

    crb_store #(.ADDR_W(ADDR_W), .ID_BYTE(ID_BYTE)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (do_write),
        .addr    (ptr_addr),
        .wdata   (wr_data),
        .rbyte   (fetch),
        .en_both (dev_enabled)
    );

    // read byte register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= 8'h00;
        else if (do_read) rd_data <= fetch;
    end
endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xact_start,
    input logic              wr_valid,
    input logic [7:0]        wr_data,
    input logic              rd_strobe,
    input logic [7:0]        rd_data,
    input logic              dev_enabled,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              ptr_mode,
    input logic              in_ptr,
    input logic              in_data
);
    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ptr && wr_valid && !xact_start) |=>
            (ptr_addr == $past(wr_data[ADDR_W-1:0]) && ptr_mode == $past(wr_data[7])));

    // R3
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !ptr_mode && !xact_start && (wr_valid || rd_strobe)) |=>
            ($stable(ptr_addr) && $stable(ptr_mode)));

    // R4 R5
    step_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && ptr_mode && !xact_start && (wr_valid || rd_strobe)) |=>
            (ptr_addr == $past(ptr_addr) + 1'b1 && ptr_mode));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // R11
    en_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_enabled) |-> $past(wr_valid));
endmodule

bind ctlreg_bank crb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xact_start  (xact_start),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .rd_strobe   (rd_strobe),
    .rd_data     (rd_data),
    .dev_enabled (dev_enabled),
    .ptr_addr    (ptr_addr),
    .ptr_mode    (ptr_mode),
    .in_ptr      (in_ptr),
    .in_data     (in_data)
);

// File: tb/sim_ctlreg_bank.sv
module sim_ctlreg_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xact_start = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       dev_enabled;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctlreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .xact_start(xact_start),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .dev_enabled(dev_enabled)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic begin_x();
        @(negedge clk) xact_start = 1'b1;
        @(negedge clk) xact_start = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] d);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) begin rd_strobe = 1'b0; d = rd_data; end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        begin_x(); put({1'b0, a[6:0]}); put(d);
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        begin_x(); put({1'b0, a[6:0]}); get(d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 dev_enabled", {7'd0, dev_enabled}, 8'h00);
        // R13: strobes before any transaction
        put(8'h83); put(8'hFF); get(v);
        check("R13 pre-start read", v, 8'h00);
        peek(8'h03, v);
        check("R1 reg03 default", v, 8'h00);
        peek(8'h12, v);
        check("R1 ratio default", v, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        begin_x(); put(8'h02); put(8'hFF); put(8'h01);
        begin_x(); put(8'h02); get(v);
        check("R3 last write wins", v, 8'h01);
        get(v);
        check("R3 repeated read", v, 8'h01);
        peek(8'h03, v);
        check("R3 neighbour untouched", v, 8'h00);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        logic [7:0] adr [5] = '{8'h04, 8'h05, 8'h16, 8'h17, 8'h1E};
        logic [7:0] msk [5] = '{8'h1F, 8'h09, 8'h98, 8'h30, 8'hE0};
        for (int i = 0; i < 5; i++) begin
            poke(adr[i], 8'hFF);
            peek(adr[i], v);
            check("R7 mask", v, msk[i]);
        end
    endtask

    task automatic t_ident();
        logic [7:0] v;
        peek(8'h01, v);
        check("R6 id", v, 8'h1A);
        poke(8'h01, 8'h00);
        peek(8'h01, v);
        check("R6 id after write", v, 8'h1A);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        poke(8'h40, 8'h55);
        peek(8'h40, v);
        check("R8 unmapped 40h", v, 8'h00);
        poke(8'h00, 8'hAA);
        peek(8'h00, v);
        check("R8 unmapped 00h", v, 8'h00);
    endtask

    task automatic t_block();
        logic [7:0] v;
        begin_x(); put(8'h86);
        for (int k = 0; k < 16; k++) put(8'(k * 37 + 5));
        begin_x(); put(8'h86);
        for (int k = 0; k < 16; k++) begin
            get(v);
            check("R4 R9 ratio byte", v, 8'(k * 37 + 5));
        end
        // R10: pointer now 16h, stepping on; no pointer byte sent
        begin_x(); get(v);
        check("R10 resume 16h", v, 8'h98);
        get(v);
        check("R10 resume 17h", v, 8'h30);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        begin_x(); put(8'hFF);
        put(8'h12); put(8'h34); put(8'h56); put(8'h02);
        peek(8'h02, v);
        check("R5 wrap write lands 02h", v, 8'h02);
        begin_x(); put(8'hFE);
        get(v); check("R5 read 7Eh", v, 8'h00);
        get(v); check("R5 read 7Fh", v, 8'h00);
        get(v); check("R5 read 00h", v, 8'h00);
        get(v); check("R5 read 01h after wrap", v, 8'h1A);
    endtask

    task automatic t_enable();
        poke(8'h05, 8'h00);
        poke(8'h03, 8'h01);
        check("R11 only 03h set", {7'd0, dev_enabled}, 8'h00);
        poke(8'h05, 8'h01);
        check("R11 both set", {7'd0, dev_enabled}, 8'h01);
        poke(8'h03, 8'h00);
        check("R11 03h cleared", {7'd0, dev_enabled}, 8'h00);
    endtask

    task automatic t_rdhold();
        logic [7:0] v;
        peek(8'h01, v);
        put(8'h00);
        repeat (3) @(negedge clk);
        check("R12 held", rd_data, 8'h1A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_masks();
        t_ident();
        t_unmapped();
        t_block();
        t_wrap();
        t_enable();
        t_rdhold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule